// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns one floating-point operand into a signed 32-bit integer word. A format select picks between a 32-bit single-precision operand and a 64-bit double-precision operand formed from two 32-bit words. The conversion drops the fraction, so it rounds toward zero. Values outside the integer range saturate, and the saturation value depends on the format and on the operand's raw sign bit.

The same datapath also runs two sign-only operations on the high (even) word of the operand. Absolute value clears the top bit, and negate flips it. Neither operation looks at the operand's numeric value.

Operands arrive on a valid/ready input. Each accepted operand produces one registered result word on a valid/ready output in the next cycle. A result is held stable for as long as the consumer stalls.

Top module: `ftrunc_cvt`

## Requirements
- R1: In single mode (`in_dbl`=0) the operand is `in_hi` (sign bit 31, exponent bits 30:23, fraction bits 22:0, bias 127). Finite values of magnitude at least 1.0 and below 2^31 give the signed integer truncated toward zero, in two's complement.
- R2: Any operand of magnitude below 1.0 gives 0 in either mode. This covers +0, -0 and denormals.
- R3: In single mode, a positive operand at or above 2^31, including +Inf, is first capped at 2147483520.0 and gives 0x7FFFFF80.
- R4: A NaN (all-ones exponent, nonzero fraction) gives 0x7FFFFFFF when its sign bit is clear and 0x80000000 when its sign bit is set, in either mode.
- R5: A negative operand at or below -2^31, including -Inf, gives 0x80000000 in either mode.
- R6: In double mode (`in_dbl`=1) the operand is {`in_hi`,`in_lo`}: sign bit 63, exponent bits 62:52 (bias 1023), fraction bits 51:0. Fraction bits held in `in_lo` take part in truncation. A positive value at or above 2^31, including +Inf, gives 0x7FFFFFFF.
- R7: Absolute value returns `in_hi` with bit 31 cleared. Negate returns `in_hi` with bit 31 inverted. In both cases bits 30:0 pass through unchanged, and `in_lo` and `in_dbl` have no effect.
- R8: `in_op` encodes the operation as 2'b00 truncate, 2'b01 absolute value, 2'b10 negate, and 2'b11 truncate.
- R9: `in_ready` equals (!`out_valid` || `out_ready`). An operand accepted at a clock edge raises `out_valid` with its result from that same edge. While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold.
- R10: During and right after reset, `out_valid` is 0, `out_word` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand presented |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_dbl | input | 1 | 1 selects the 64-bit format |
| in_op | input | 2 | Operation code |
| in_hi | input | 32 | Single operand, or high/even word of the double operand |
| in_lo | input | 32 | Low/odd word of the double operand |
| out_valid | output | 1 | Result word held |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Result word |

## Verification
The bench builds the block with its default formats: 8/23 exponent/fraction bits for single, 11/52 for double, and a 32-bit result. With these defaults every exponent boundary around 2^31 can be reached directly with exact operand patterns. The tests include the largest single below 2^31, exactly ±2^31, -2^31-1, and ±(2^31-1) in double. They also cover the capped single overflow against the uncapped double one, and NaN and infinity of each sign. A stall sequence then shows a second operand waiting behind a held result.

// File: rtl/ftrunc_cvt_pkg.sv
package ftrunc_cvt_pkg;

    localparam int RES_W     = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_MAN_W  = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_MAN_W  = 52;
    localparam int DP_HI_MAN = DP_MAN_W - RES_W;   // fraction bits kept in the high word

    // positive saturation values per format
    localparam logic [RES_W-1:0] SP_POS_CAP = 32'h7FFF_FF80;
    localparam logic [RES_W-1:0] DP_POS_CAP = 32'h7FFF_FFFF;

    typedef enum logic [1:0] {
        OP_TRUNC  = 2'b00,
        OP_ABS    = 2'b01,
        OP_NEG    = 2'b10,
        OP_TRUNC2 = 2'b11
    } cvt_op_e;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] word;
    } out_st_t;

endpackage

// File: rtl/ftrunc_core.sv
// Generic truncating converter for one IEEE-754 format.
module ftrunc_core #(
    parameter int               EXP_W   = 8,
    parameter int               MAN_W   = 23,
    parameter int               RES_W   = 32,
    parameter logic [RES_W-1:0] POS_CAP = 32'h7FFF_FFFF
) (
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [RES_W-1:0] res_o
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int WIDE_W = MAN_W + RES_W;
    localparam int SH_W   = $clog2(RES_W);
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int LIMIT  = BIAS + RES_W - 1;          // first exponent out of range
    localparam logic [RES_W-1:0] MIN_INT = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] MAX_INT = ~MIN_INT;

    logic              exp_max;
    logic              is_nan;
    logic              too_big;
    logic              too_small;
    logic [SH_W-1:0]   shamt;
    logic [WIDE_W-1:0] wide;
    logic [RES_W-2:0]  mag;
    logic [RES_W-1:0]  mag_ext;

    always_comb begin
        exp_max   = &exp_i;
        is_nan    = exp_max && (man_i != '0);
        too_big   = exp_i >= EXP_W'(LIMIT);
        too_small = exp_i <  EXP_W'(BIAS);
        shamt     = SH_W'(exp_i - EXP_W'(BIAS));
        wide      = WIDE_W'({1'b1, man_i}) << shamt;
        mag       = wide[MAN_W +: RES_W-1];
        mag_ext   = {1'b0, mag};

        if (is_nan) begin
            res_o = sign_i ? MIN_INT : MAX_INT;
        end else if (too_big) begin
            res_o = sign_i ? MIN_INT : POS_CAP;
        end else if (too_small) begin
            res_o = '0;
        end else begin
            res_o = sign_i ? (~mag_ext + 1'b1) : mag_ext;
        end
    end

    initial begin
        if (SIG_W + RES_W - 1 != WIDE_W) $error("width mismatch");
    end
endmodule

// File: rtl/ftrunc_sign_op.sv
// Sign-only operations on a raw word.
module ftrunc_sign_op
    import ftrunc_cvt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word_i,
    input  cvt_op_e      op_i,
    output logic [W-1:0] word_o
);
    always_comb begin
        unique case (op_i)
            OP_ABS:  word_o = {1'b0, word_i[W-2:0]};
            OP_NEG:  word_o = {~word_i[W-1], word_i[W-2:0]};
            default: word_o = word_i;
        endcase
    end
endmodule

// File: rtl/ftrunc_cvt.sv
module ftrunc_cvt
    import ftrunc_cvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dbl,
    input  logic [1:0]       in_op,
    input  logic [RES_W-1:0] in_hi,
    input  logic [RES_W-1:0] in_lo,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [RES_W-1:0] out_word
);
    cvt_op_e          op;
    logic [RES_W-1:0] sp_res;
    logic [RES_W-1:0] dp_res;
    logic [RES_W-1:0] sgn_res;
    logic [RES_W-1:0] cvt_res;
    out_st_t          st_d;
    out_st_t          st_q;

    assign op = cvt_op_e'(in_op);

    ftrunc_core #(
        .EXP_W  (SP_EXP_W),
        .MAN_W  (SP_MAN_W),
        .RES_W  (RES_W),
        .POS_CAP(SP_POS_CAP)
    ) u_sp (
        .sign_i(in_hi[RES_W-1]),
        .exp_i (in_hi[SP_MAN_W +: SP_EXP_W]),
        .man_i (in_hi[SP_MAN_W-1:0]),
        .res_o (sp_res)
    );

    ftrunc_core #(
        .EXP_W  (DP_EXP_W),
        .MAN_W  (DP_MAN_W),
        .RES_W  (RES_W),
        .POS_CAP(DP_POS_CAP)
    ) u_dp (
        .sign_i(in_hi[RES_W-1]),
        .exp_i (in_hi[DP_HI_MAN +: DP_EXP_W]),
        .man_i ({in_hi[DP_HI_MAN-1:0], in_lo}),
        .res_o (dp_res)
    );

    ftrunc_sign_op #(.W(RES_W)) u_sgn (
        .word_i(in_hi),
        .op_i  (op),
        .word_o(sgn_res)
    );

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        cvt_res = in_dbl ? dp_res : sp_res;
        st_d    = st_q;
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.word  = (op == OP_ABS || op == OP_NEG) ? sgn_res : cvt_res;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
endmodule

// File: rtl/ftrunc_cvt_chk.sv
module ftrunc_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_dbl,
    input logic [1:0]  in_op,
    input logic [31:0] in_hi,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word
);
    logic acc;
    assign acc = in_valid && in_ready;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    p_neg_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_op[0] && !in_op[1] && !in_dbl && in_hi[31] && (in_hi[30:23] >= 8'd158))
        |=> (out_word == 32'h8000_0000));

    p_small_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_op[0] && !in_op[1] && !in_dbl && (in_hi[30:23] < 8'd127))
        |=> (out_word == 32'd0));

    p_abs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'b01)
        |=> (!out_word[31] && out_word[30:0] == $past(in_hi[30:0])));

    p_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 2'b10)
        |=> (out_word == {~$past(in_hi[31]), $past(in_hi[30:0])}));

    p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid) |-> in_ready);
endmodule

bind ftrunc_cvt ftrunc_cvt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_dbl   (in_dbl),
    .in_op    (in_op),
    .in_hi    (in_hi),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_word (out_word)
);

// File: tb/ftrunc_cvt_bench.sv
module ftrunc_cvt_bench;

    typedef struct packed {
        logic        dbl;
        logic [1:0]  op;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        // R1 single in-range truncation
        '{1'b0, 2'b00, 32'h3F80_0000, 32'h0, 32'h0000_0001, 8'd1},
        '{1'b0, 2'b00, 32'hBF80_0000, 32'h0, 32'hFFFF_FFFF, 8'd1},
        '{1'b0, 2'b00, 32'h4049_0FDB, 32'h0, 32'h0000_0003, 8'd1},
        '{1'b0, 2'b00, 32'hC049_0FDB, 32'h0, 32'hFFFF_FFFD, 8'd1},
        '{1'b0, 2'b00, 32'h3FC0_0000, 32'h0, 32'h0000_0001, 8'd1},
        '{1'b0, 2'b00, 32'hBFC0_0000, 32'h0, 32'hFFFF_FFFF, 8'd1},
        '{1'b0, 2'b00, 32'h4B00_0001, 32'h0, 32'h0080_0001, 8'd1},
        '{1'b0, 2'b00, 32'hCEFF_FFFF, 32'h0, 32'h8000_0080, 8'd1},
        '{1'b0, 2'b00, 32'h3F80_0000, 32'hFFFF_FFFF, 32'h0000_0001, 8'd1},
        // R2 small magnitudes
        '{1'b0, 2'b00, 32'h3F7F_FFFF, 32'h0, 32'h0, 8'd2},
        '{1'b0, 2'b00, 32'h8000_0000, 32'h0, 32'h0, 8'd2},
        '{1'b0, 2'b00, 32'h0000_0001, 32'h0, 32'h0, 8'd2},
        '{1'b1, 2'b00, 32'h3FE8_0000, 32'h0, 32'h0, 8'd2},
        '{1'b1, 2'b00, 32'h0000_0000, 32'h1, 32'h0, 8'd2},
        // R3 single positive cap
        '{1'b0, 2'b00, 32'h4EFF_FFFF, 32'h0, 32'h7FFF_FF80, 8'd3},
        '{1'b0, 2'b00, 32'h4F00_0000, 32'h0, 32'h7FFF_FF80, 8'd3},
        '{1'b0, 2'b00, 32'h7F80_0000, 32'h0, 32'h7FFF_FF80, 8'd3},
        // R4 NaNs by sign
        '{1'b0, 2'b00, 32'h7FC0_0000, 32'h0, 32'h7FFF_FFFF, 8'd4},
        '{1'b0, 2'b00, 32'hFFC0_0000, 32'h0, 32'h8000_0000, 8'd4},
        '{1'b1, 2'b00, 32'h7FF8_0000, 32'h0, 32'h7FFF_FFFF, 8'd4},
        '{1'b1, 2'b00, 32'hFFF0_0000, 32'h1, 32'h8000_0000, 8'd4},
        // R5 negative saturation
        '{1'b0, 2'b00, 32'hCF00_0000, 32'h0, 32'h8000_0000, 8'd5},
        '{1'b0, 2'b00, 32'hCF00_0001, 32'h0, 32'h8000_0000, 8'd5},
        '{1'b0, 2'b00, 32'hFF80_0000, 32'h0, 32'h8000_0000, 8'd5},
        '{1'b1, 2'b00, 32'hC1E0_0000, 32'h0, 32'h8000_0000, 8'd5},
        '{1'b1, 2'b00, 32'hC1E0_0000, 32'h0020_0000, 32'h8000_0000, 8'd5},
        '{1'b1, 2'b00, 32'hFFF0_0000, 32'h0, 32'h8000_0000, 8'd5},
        // R6 double mode
        '{1'b1, 2'b00, 32'h3FF0_0000, 32'h0, 32'h0000_0001, 8'd6},
        '{1'b1, 2'b00, 32'hC004_0000, 32'h0, 32'hFFFF_FFFE, 8'd6},
        '{1'b1, 2'b00, 32'h41DF_FFFF, 32'hFFC0_0000, 32'h7FFF_FFFF, 8'd6},
        '{1'b1, 2'b00, 32'h41DF_FFFF, 32'hFFE0_0000, 32'h7FFF_FFFF, 8'd6},
        '{1'b1, 2'b00, 32'hC1DF_FFFF, 32'hFFC0_0000, 32'h8000_0001, 8'd6},
        '{1'b1, 2'b00, 32'h4140_0000, 32'h8000_0000, 32'h0020_0001, 8'd6},
        '{1'b1, 2'b00, 32'h41E0_0000, 32'h0, 32'h7FFF_FFFF, 8'd6},
        '{1'b1, 2'b00, 32'h7FF0_0000, 32'h0, 32'h7FFF_FFFF, 8'd6},
        // R7 sign-only operations
        '{1'b0, 2'b01, 32'hC049_0FDB, 32'h0, 32'h4049_0FDB, 8'd7},
        '{1'b0, 2'b10, 32'h4049_0FDB, 32'h0, 32'hC049_0FDB, 8'd7},
        '{1'b1, 2'b10, 32'h3FF0_0000, 32'h1234_5678, 32'hBFF0_0000, 8'd7},
        '{1'b1, 2'b01, 32'h7FF8_0000, 32'hFFFF_FFFF, 32'h7FF8_0000, 8'd7},
        // R8 alternate truncate code
        '{1'b0, 2'b11, 32'hC049_0FDB, 32'h0, 32'hFFFF_FFFD, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_dbl = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_hi = '0;
    logic [31:0] in_lo = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ftrunc_cvt u_ftrunc_cvt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_dbl   (in_dbl),
        .in_op    (in_op),
        .in_hi    (in_hi),
        .in_lo    (in_lo),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_word (out_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic d, input logic [1:0] o, input logic [31:0] h, input logic [31:0] l);
        in_dbl   = d;
        in_op    = o;
        in_hi    = h;
        in_lo    = l;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R10 out_word in reset", out_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 in_ready after reset", {31'b0, in_ready}, 32'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].dbl, VECS[i].op, VECS[i].hi, VECS[i].lo);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec %0d valid", VECS[i].req, i), {31'b0, out_valid}, 32'd1);
            check($sformatf("R%0d vec %0d word", VECS[i].req, i), out_word, VECS[i].exp);
        end
        @(negedge clk);
        check("R9 valid drops when idle", {31'b0, out_valid}, 32'd0);

        // R9 backpressure: result A held, B waits
        out_ready = 1'b0;
        drive(1'b0, 2'b00, 32'h4120_0000, 32'h0);       // 10.0 -> 10
        @(negedge clk);
        check("R9 ready low while stalled", {31'b0, in_ready}, 32'd0);
        check("R9 first result", out_word, 32'd10);
        drive(1'b1, 2'b00, 32'hC034_0000, 32'h0);       // -20.0 -> -20
        @(negedge clk);
        check("R9 held word", out_word, 32'd10);
        check("R9 held valid", {31'b0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 queued operand taken", out_word, 32'hFFFF_FFEC);
        @(negedge clk);
        check("R9 valid cleared after drain", {31'b0, out_valid}, 32'd0);

        // R10 reset mid-stream clears output
        drive(1'b0, 2'b00, 32'h3F80_0000, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 valid cleared by reset", {31'b0, out_valid}, 32'd0);
        check("R10 word cleared by reset", out_word, 32'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule